// File: doc/BRIEF.md
# Selectable Tone Mixer for Audio Samples

This block shifts the spectrum of an audio-rate sample stream by multiplying each sample with a stored sinusoidal local oscillator. Samples are 8-bit offset binary and arrive on a single-cycle sample strobe from the system clock, nominally at 50 kHz. The block flips the sample's top bit to get two's complement. It then either forwards that value unchanged or multiplies it by one of three tones: 10 kHz, 14 kHz or 20 kHz, each sampled at the 50 kHz rate.

All three tones come from one 25-entry sign-magnitude sine table. Three phase counters step through it with strides of 5, 7 and 10 entries. Every counter moves on every strobe, whichever tone is selected. The product of the sample magnitude and the tone magnitude is cut down to a fixed 6-bit slice, so large products wrap instead of saturating. The result is one 8-bit two's-complement sample per strobe, registered.

Top module: `lo_mixer`

## Requirements
- R1: With `freqSel` = 00, the output is the captured input sample with only bit 7 inverted (offset binary to two's complement).
- R2: A sample captured at one strobe appears at `mixOut` at the next strobe edge. `mixOut` changes on no other edge.
- R3: After reset, `mixOut` is 0 and all tone phases are at table index 0. The first strobe after reset therefore outputs 0.
- R4: Counting strobes from reset, the sample taken at strobe n (n = 1, 2, ...) is mixed with table index (stride·n) mod 25. The strides are 5 for 10 kHz (`freqSel` = 01), 7 for 14 kHz (10) and 10 for 20 kHz (11).
- R5: The table T has 25 entries. For k = 0..12, T[k] = 0, 32, 62, 88, 108, 122, 127, 126, 116, 99, 75, 47, 16. For k = 13..24, T[k] = -T[25-k]. This gives 0, +122, +75, -75, -122 at 10 kHz and 0, +75, -122, +122, -75 at 20 kHz.
- R6: The mixed result is computed in four steps. Take the absolute value of the two's-complement sample. Multiply it by the 7-bit tone magnitude. Keep product bits 12:7 as a 6-bit magnitude and drop the higher bits. Negate that magnitude in 8 bits when the sample sign differs from the tone sign (a zero tone counts as positive).
- R7: All three phase counters advance on every strobe, whatever `freqSel` holds. Changing the select mid-stream therefore picks up the new tone at the index given by the strobe count.
- R8: Without a strobe, changes on `sampleIn` or `freqSel` have no effect: the output holds, and phases do not move.
- R9: In a mixing mode the output magnitude never exceeds 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| sampleEn | input | 1 | One-cycle strobe per audio sample |
| sampleIn | input | 8 | Offset-binary input sample |
| freqSel | input | 2 | 00 unmixed, 01 10 kHz, 10 14 kHz, 11 20 kHz |
| mixOut | output | 8 | Two's-complement output sample |

## Verification
Every result is due exactly one strobe after its sample is captured. The bench raises `sampleEn` for one cycle and samples `mixOut` at the falling edge after that strobe's rising edge. It compares the value against the model's prediction for the sample from the previous strobe, taken with the phase set by the number of earlier strobes. Gaps of random length between strobes are checked for a held output while the inputs toggle. Each check waits for the next strobe before comparing, so no result is read early.

// File: rtl/lo_mix_pkg.sv
package lo_mix_pkg;
  localparam int SampleW  = 8;
  localparam int MagW     = SampleW - 1;
  localparam int TableLen = 25;
  localparam int HalfLen  = TableLen / 2;
  localparam int PhaseW   = $clog2(TableLen);
  localparam int NumTones = 3;
  localparam int SelW     = 2;
  localparam int SliceLo  = MagW;
  localparam int SliceW   = 6;
  localparam int ProdW    = SampleW + MagW;

  // phase strides for 10k, 14k, 20k tones
  localparam logic [NumTones-1:0][PhaseW-1:0] ToneStride = {5'd10, 5'd7, 5'd5};

  typedef struct packed {
    logic                             step;
    logic [NumTones-1:0][PhaseW-1:0]  phase;
  } mixCtrl_t;

  function automatic logic [MagW-1:0] halfMag(input logic [PhaseW-1:0] k);
    case (k)
      5'd1:    halfMag = 7'd32;
      5'd2:    halfMag = 7'd62;
      5'd3:    halfMag = 7'd88;
      5'd4:    halfMag = 7'd108;
      5'd5:    halfMag = 7'd122;
      5'd6:    halfMag = 7'd127;
      5'd7:    halfMag = 7'd126;
      5'd8:    halfMag = 7'd116;
      5'd9:    halfMag = 7'd99;
      5'd10:   halfMag = 7'd75;
      5'd11:   halfMag = 7'd47;
      5'd12:   halfMag = 7'd16;
      default: halfMag = 7'd0;
    endcase
  endfunction

  // sign-magnitude tone entry: bit 7 sign, bits 6:0 magnitude
  function automatic logic [SampleW-1:0] toneEntry(input logic [PhaseW-1:0] idx);
    logic [PhaseW-1:0] mirror;
    mirror = PhaseW'(TableLen) - idx;
    if (idx <= PhaseW'(HalfLen)) toneEntry = {1'b0, halfMag(idx)};
    else                         toneEntry = {1'b1, halfMag(mirror)};
  endfunction
endpackage

// File: rtl/lo_mix_ctrl.sv
module lo_mix_ctrl
  import lo_mix_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sampleEn,
  output mixCtrl_t ctrl
);
  logic [NumTones-1:0][PhaseW-1:0] phaseQ;

  for (genvar t = 0; t < NumTones; t++) begin : g_tone
    logic [PhaseW:0] sum;
    always_comb sum = {1'b0, phaseQ[t]} + {1'b0, ToneStride[t]};

    always_ff @(posedge clk or posedge rst) begin
      if (rst)           phaseQ[t] <= '0;
      else if (sampleEn) phaseQ[t] <= (sum >= (PhaseW+1)'(TableLen))
                                      ? PhaseW'(sum - (PhaseW+1)'(TableLen))
                                      : sum[PhaseW-1:0];
    end

    p_phase_range_r4: assert property (@(posedge clk) disable iff (rst)
      phaseQ[t] < PhaseW'(TableLen));
    p_phase_step_r7: assert property (@(posedge clk) disable iff (rst)
      sampleEn |=> (32'(phaseQ[t]) ==
                    (32'($past(phaseQ[t])) + 32'(ToneStride[t])) % TableLen));
    p_phase_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !sampleEn |=> $stable(phaseQ[t]));
  end

  always_comb begin
    ctrl.step  = sampleEn;
    ctrl.phase = phaseQ;
  end
endmodule

// File: rtl/lo_mix_datapath.sv
module lo_mix_datapath
  import lo_mix_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  mixCtrl_t           ctrl,
  input  logic [SampleW-1:0] sampleIn,
  input  logic [SelW-1:0]    freqSel,
  output logic [SampleW-1:0] mixOut
);
  logic [SampleW-1:0] convQ;
  logic [SampleW-1:0] outQ;
  logic [SampleW-1:0] toneByte;
  logic [SampleW-1:0] sampMag;
  logic [ProdW-1:0]   prod;
  logic [SliceW-1:0]  slice;
  logic [SampleW-1:0] mixed;
  logic [SampleW-1:0] nextOut;
  logic [SelW-1:0]    toneIdx;

  always_comb begin
    toneIdx  = freqSel - SelW'(1);
    toneByte = toneEntry(ctrl.phase[toneIdx]);
    sampMag  = convQ[SampleW-1] ? (~convQ + SampleW'(1)) : convQ;
    prod     = ProdW'(sampMag) * ProdW'(toneByte[MagW-1:0]);
    slice    = prod[SliceLo +: SliceW];
    mixed    = (convQ[SampleW-1] ^ toneByte[SampleW-1])
               ? (~SampleW'(slice) + SampleW'(1)) : SampleW'(slice);
    nextOut  = (freqSel == '0) ? convQ : mixed;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      convQ <= '0;
      outQ  <= '0;
    end else if (ctrl.step) begin
      convQ <= {~sampleIn[SampleW-1], sampleIn[SampleW-2:0]};
      outQ  <= nextOut;
    end
  end

  assign mixOut = outQ;

  p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ctrl.step |=> $stable(mixOut));
  p_pass_conv_r1: assert property (@(posedge clk) disable iff (rst)
    (ctrl.step && freqSel == '0) |=> (mixOut == $past(convQ)));
  p_mix_range_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrl.step && freqSel != '0) |=>
      ($signed(mixOut) <= 8'sd63 && $signed(mixOut) >= -8'sd63));
endmodule

// File: rtl/lo_mixer.sv
module lo_mixer
  import lo_mix_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sampleEn,
  input  logic [SampleW-1:0] sampleIn,
  input  logic [SelW-1:0]    freqSel,
  output logic [SampleW-1:0] mixOut
);
  mixCtrl_t ctrl;

  lo_mix_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sampleEn (sampleEn),
    .ctrl     (ctrl)
  );

  lo_mix_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .sampleIn (sampleIn),
    .freqSel  (freqSel),
    .mixOut   (mixOut)
  );

  p_reset_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mixOut == '0));
endmodule

// File: tb/lo_mixer_bench.sv
module lo_mixer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sampleEn = 1'b0;
  logic [7:0] sampleIn = 8'h00;
  logic [1:0] freqSel = 2'b00;
  logic [7:0] mixOut;

  int checks = 0;
  int fails = 0;
  int strobeCount = 0;
  logic [7:0] prevConv = 8'h00;

  always #2 clk = ~clk;

  lo_mixer u_lo_mixer (
    .clk(clk), .rst(rst), .sampleEn(sampleEn),
    .sampleIn(sampleIn), .freqSel(freqSel), .mixOut(mixOut)
  );

  function automatic int tbl(input int k);
    int h[13] = '{0, 32, 62, 88, 108, 122, 127, 126, 116, 99, 75, 47, 16};
    if (k <= 12) return h[k];
    return -h[25 - k];
  endfunction

  function automatic int strideOf(input logic [1:0] s);
    case (s)
      2'b01:   return 5;
      2'b10:   return 7;
      default: return 10;
    endcase
  endfunction

  function automatic logic [7:0] model(input logic [7:0] conv, input logic [1:0] s,
                                       input int count);
    int sv, tv, mag, prod, sl, r;
    if (s == 2'b00) return conv;
    sv = int'($signed(conv));
    tv = tbl((strideOf(s) * count) % 25);
    mag = (sv < 0) ? -sv : sv;
    prod = mag * ((tv < 0) ? -tv : tv);
    sl = (prod >> 7) & 63;
    r = ((sv < 0) != (tv < 0)) ? -sl : sl;
    return r[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one strobe; checks the output due at this edge
  task automatic strobe(input logic [7:0] smp, input logic [1:0] s, input string req);
    logic [7:0] exp;
    exp = model(prevConv, s, strobeCount);
    sampleIn = smp;
    freqSel  = s;
    sampleEn = 1'b1;
    @(negedge clk);
    sampleEn = 1'b0;
    check(req, mixOut, exp);
    prevConv = {~smp[7], smp[6:0]};
    strobeCount++;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R3 reset output", mixOut, 8'h00);
    // R3: first strobe outputs 0 even in a mixing mode
    strobe(8'hFF, 2'b01, "R3 first strobe");
    // R1: pass-through conversion corner values
    strobe(8'h00, 2'b00, "R1 pass");
    strobe(8'h80, 2'b00, "R1 pass");
    strobe(8'h7F, 2'b00, "R1 pass");
    strobe(8'hFF, 2'b00, "R1 pass");
    // R4 R5 R6: full-scale samples through each tone
    for (int i = 0; i < 10; i++) strobe(8'h00, 2'b01, "R4 R6 10k");
    for (int i = 0; i < 26; i++) strobe(8'hFF, 2'b10, "R5 R6 14k");
    for (int i = 0; i < 10; i++) strobe(8'h00, 2'b11, "R5 R6 20k");
    // R8: idle gap with toggling inputs, output must hold
    begin
      logic [7:0] held;
      held = mixOut;
      for (int i = 0; i < 6; i++) begin
        sampleIn = 8'($urandom);
        freqSel  = 2'($urandom);
        @(negedge clk);
        check("R8 idle hold", mixOut, held);
      end
    end
    // R2 R7: random stream with select changes and gaps
    for (int i = 0; i < 400; i++) begin
      logic [7:0] held;
      strobe(8'($urandom), 2'($urandom), "R2 R6 R7 random");
      held = mixOut;
      repeat ($urandom_range(0, 3)) begin
        sampleIn = 8'($urandom);
        @(negedge clk);
        check("R2 hold between strobes", mixOut, held);
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule